// File: doc/BRIEF.md
# Bidirectional Byte Bus Buffer with Parity Generation and Checking

This block joins two 8-bit bus sides, A and B, and passes a byte between them in the direction chosen by a direction input. An active-high disable input releases both sides, so that neither side nor the shared parity pin is driven. Every tri-state pin is modelled as a separate input value, output value and output enable, and the pad ring combines them.

When sending from A to B, the block computes a parity bit over the A byte and drives it onto a shared parity pin. When receiving from B to A, the same pin is released and read as an input. The block then checks it against the B byte and pulls an active-low error flag low on a mismatch. A mode input selects even or odd parity for both directions. The datapath is purely combinational.

Top module: `xcvr_parity`

## Requirements
- R1: With dir_i=1 (transmit) and dis_i=0, b_out_o equals a_in_i, b_oe_o=1 and a_oe_o=0.
- R2: With dir_i=0 (receive) and dis_i=0, a_out_o equals b_in_i, a_oe_o=1 and b_oe_o=0.
- R3: With dis_i=1, a_oe_o, b_oe_o and par_oe_o are all 0 for either direction, and a_out_o, b_out_o and par_out_o are held at 0.
- R4: In transmit with odd_i=0 (even parity), par_out_o is 1 exactly when a_in_i has an odd number of 1 bits, so the count over A and the parity bit is even.
- R5: In transmit with odd_i=1 (odd parity), par_out_o makes the count of 1 bits over a_in_i and the parity bit odd.
- R6: par_oe_o is 1 only when dir_i=1 and dis_i=0.
- R7: In receive with odd_i=0, err_no is 0 exactly when the count of 1 bits over b_in_i and par_in_i is odd.
- R8: In receive with odd_i=1, err_no is 0 exactly when the count of 1 bits over b_in_i and par_in_i is even.
- R9: In transmit, and whenever dis_i=1, err_no is 1 whatever the B byte and par_in_i hold.
- R10: In transmit, b_in_i and par_in_i have no effect on any output. In receive, a_in_i has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dir_i | input | 1 | Transfer direction: 1 = A to B, 0 = B to A |
| dis_i | input | 1 | Active-high disable of all drivers |
| odd_i | input | 1 | Parity sense: 0 = even, 1 = odd |
| a_in_i | input | 8 | Value seen on side A pins |
| a_out_o | output | 8 | Value driven onto side A |
| a_oe_o | output | 1 | Output enable for side A |
| b_in_i | input | 8 | Value seen on side B pins |
| b_out_o | output | 8 | Value driven onto side B |
| b_oe_o | output | 1 | Output enable for side B |
| par_in_i | input | 1 | Value seen on the parity pin |
| par_out_o | output | 1 | Parity value driven onto the parity pin |
| par_oe_o | output | 1 | Output enable for the parity pin |
| err_no | output | 1 | Active-low parity error flag |

## Verification
Every output is a combinational function of the inputs, so each result is due in the same cycle as its stimulus and has no register latency. The bench applies each stimulus on the falling clock edge and samples one time unit later, after the logic has settled and well before the next rising edge. The exhaustive sweep covers all 256 byte values in both directions and both parity modes, with and without the disable. In each case the opposite side's input holds an unrelated value, so that any leakage between the sides shows up at the outputs.

// File: rtl/xcvr_parity_pkg.sv
package xcvr_parity_pkg;

  typedef enum logic {
    DIR_RX = 1'b0,
    DIR_TX = 1'b1
  } dir_e;

  typedef enum logic {
    PAR_EVEN = 1'b0,
    PAR_ODD  = 1'b1
  } par_mode_e;

  // Driver plan decoded from direction and disable
  typedef struct packed {
    logic a_drv;
    logic b_drv;
    logic par_drv;
    logic chk_en;
  } path_ctl_t;

  localparam path_ctl_t PATH_IDLE = '{a_drv: 1'b0, b_drv: 1'b0, par_drv: 1'b0, chk_en: 1'b0};

endpackage

// File: rtl/xcvr_parity_tree.sv
module xcvr_parity_tree #(
  parameter int W = 8
) (
  input  logic [W-1:0] bits_i,
  output logic         par_o
);
  localparam int LVLS  = (W > 1) ? $clog2(W) : 1;
  localparam int PW    = 1 << LVLS;
  localparam int NODES = 2 * PW - 1;

  logic [PW-1:0]    pad;
  logic [NODES-1:0] node;

  always_comb begin
    pad = '0;
    pad[W-1:0] = bits_i;
  end

  // Heap layout: leaves at PW-1.., root at 0
  for (genvar i = 0; i < PW; i++) begin : g_leaf
    assign node[PW-1+i] = pad[i];
  end

  for (genvar k = 0; k < PW - 1; k++) begin : g_xor
    assign node[k] = node[2*k+1] ^ node[2*k+2];
  end

  assign par_o = node[0];

endmodule

// File: rtl/xcvr_parity_ctl.sv
module xcvr_parity_ctl
  import xcvr_parity_pkg::*;
(
  input  dir_e      dir_i,
  input  logic      dis_i,
  output path_ctl_t ctl_o
);
  always_comb begin
    ctl_o = PATH_IDLE;
    if (!dis_i) begin
      unique case (dir_i)
        DIR_TX: begin
          ctl_o.b_drv   = 1'b1;
          ctl_o.par_drv = 1'b1;
        end
        DIR_RX: begin
          ctl_o.a_drv  = 1'b1;
          ctl_o.chk_en = 1'b1;
        end
        default: ctl_o = PATH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/xcvr_parity_lane.sv
module xcvr_parity_lane #(
  parameter int W = 8
) (
  input  logic         en_i,
  input  logic [W-1:0] src_i,
  output logic [W-1:0] out_o,
  output logic         oe_o
);
  // Gated pass-through; value parked at zero when released
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign out_o[i] = en_i & src_i[i];
  end
  assign oe_o = en_i;

endmodule

// File: rtl/xcvr_parity.sv
module xcvr_parity
  import xcvr_parity_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              dir_i,
  input  logic              dis_i,
  input  logic              odd_i,
  input  logic [DATA_W-1:0] a_in_i,
  output logic [DATA_W-1:0] a_out_o,
  output logic              a_oe_o,
  input  logic [DATA_W-1:0] b_in_i,
  output logic [DATA_W-1:0] b_out_o,
  output logic              b_oe_o,
  input  logic              par_in_i,
  output logic              par_out_o,
  output logic              par_oe_o,
  output logic              err_no
);
  localparam int CHK_W = DATA_W + 1;

  path_ctl_t  ctl;
  logic       a_xor;
  logic       chk_xor;
  logic [CHK_W-1:0] chk_vec;

  xcvr_parity_ctl u_ctl (
    .dir_i (dir_e'(dir_i)),
    .dis_i (dis_i),
    .ctl_o (ctl)
  );

  xcvr_parity_tree #(.W(DATA_W)) u_gen (
    .bits_i (a_in_i),
    .par_o  (a_xor)
  );

  assign chk_vec = {par_in_i, b_in_i};

  xcvr_parity_tree #(.W(CHK_W)) u_chk (
    .bits_i (chk_vec),
    .par_o  (chk_xor)
  );

  xcvr_parity_lane #(.W(DATA_W)) u_a_lane (
    .en_i  (ctl.a_drv),
    .src_i (b_in_i),
    .out_o (a_out_o),
    .oe_o  (a_oe_o)
  );

  xcvr_parity_lane #(.W(DATA_W)) u_b_lane (
    .en_i  (ctl.b_drv),
    .src_i (a_in_i),
    .out_o (b_out_o),
    .oe_o  (b_oe_o)
  );

  assign par_out_o = ctl.par_drv & (a_xor ^ odd_i);
  assign par_oe_o  = ctl.par_drv;
  // Error when total parity disagrees with mode
  assign err_no    = ~(ctl.chk_en & (chk_xor ^ odd_i));

endmodule

// File: rtl/xcvr_parity_chk.sv
module xcvr_parity_chk #(
  parameter int DATA_W = 8
) (
  input logic              dir_i,
  input logic              dis_i,
  input logic              odd_i,
  input logic [DATA_W-1:0] a_in_i,
  input logic [DATA_W-1:0] a_out_o,
  input logic              a_oe_o,
  input logic [DATA_W-1:0] b_in_i,
  input logic [DATA_W-1:0] b_out_o,
  input logic              b_oe_o,
  input logic              par_in_i,
  input logic              par_out_o,
  input logic              par_oe_o,
  input logic              err_no
);
  always_comb begin
    // R1
    tx_path_chk: assert (!(dir_i && !dis_i) || (b_oe_o && !a_oe_o && b_out_o == a_in_i));
    // R2
    rx_path_chk: assert (!(!dir_i && !dis_i) || (a_oe_o && !b_oe_o && a_out_o == b_in_i));
    // R3
    dis_quiet_chk: assert (!dis_i || (!a_oe_o && !b_oe_o && !par_oe_o));
    // R4
    tx_even_chk: assert (!(par_oe_o && !odd_i) || ($countones({a_in_i, par_out_o}) % 2 == 0));
    // R5
    tx_odd_chk: assert (!(par_oe_o && odd_i) || ($countones({a_in_i, par_out_o}) % 2 == 1));
    // R6
    par_oe_chk: assert (!par_oe_o || (dir_i && !dis_i));
    // R7
    rx_even_chk: assert (!(a_oe_o && !odd_i) || (err_no == ($countones({b_in_i, par_in_i}) % 2 == 0)));
    // R8
    rx_odd_chk: assert (!(a_oe_o && odd_i) || (err_no == ($countones({b_in_i, par_in_i}) % 2 == 1)));
    // R9
    err_idle_chk: assert (!(dir_i || dis_i) || err_no);
    // R3
    no_contention_chk: assert ($countones({a_oe_o, b_oe_o}) <= 1);
  end

endmodule

bind xcvr_parity xcvr_parity_chk #(.DATA_W(DATA_W)) u_xcvr_parity_chk (
  .dir_i     (dir_i),
  .dis_i     (dis_i),
  .odd_i     (odd_i),
  .a_in_i    (a_in_i),
  .a_out_o   (a_out_o),
  .a_oe_o    (a_oe_o),
  .b_in_i    (b_in_i),
  .b_out_o   (b_out_o),
  .b_oe_o    (b_oe_o),
  .par_in_i  (par_in_i),
  .par_out_o (par_out_o),
  .par_oe_o  (par_oe_o),
  .err_no    (err_no)
);

// File: tb/xcvr_parity_test.sv
`timescale 1ns/1ps
module xcvr_parity_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic         dir_i, dis_i, odd_i, par_in_i;
  logic [W-1:0] a_in_i, b_in_i;
  logic [W-1:0] a_out_o, b_out_o;
  logic         a_oe_o, b_oe_o, par_out_o, par_oe_o, err_no;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  xcvr_parity #(.DATA_W(W)) uut (
    .dir_i(dir_i), .dis_i(dis_i), .odd_i(odd_i),
    .a_in_i(a_in_i), .a_out_o(a_out_o), .a_oe_o(a_oe_o),
    .b_in_i(b_in_i), .b_out_o(b_out_o), .b_oe_o(b_oe_o),
    .par_in_i(par_in_i), .par_out_o(par_out_o), .par_oe_o(par_oe_o),
    .err_no(err_no)
  );

  function automatic int ones(input logic [W-1:0] v);
    int c = 0;
    for (int i = 0; i < W; i++) c += int'(v[i]);
    return c;
  endfunction

  function automatic logic exp_par(input logic [W-1:0] a, input logic odd);
    // even: total even; odd: total odd
    return ((ones(a) % 2) == 1) ? ~odd : odd;
  endfunction

  function automatic logic exp_err_n(input logic d, input logic s, input logic odd,
                                     input logic [W-1:0] b, input logic p);
    int tot;
    if (d || s) return 1'b1;
    tot = ones(b) + int'(p);
    if (!odd) return (tot % 2 == 0);
    return (tot % 2 == 1);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s dir=%0b dis=%0b odd=%0b a=%02h b=%02h p=%0b act=%0h exp=%0h",
               req, dir_i, dis_i, odd_i, a_in_i, b_in_i, par_in_i, act, exp);
    end
  endtask

  task automatic apply(input logic d, input logic s, input logic o,
                       input logic [W-1:0] a, input logic [W-1:0] b, input logic p);
    @(negedge clk);
    dir_i = d; dis_i = s; odd_i = o; a_in_i = a; b_in_i = b; par_in_i = p;
    #1;
    if (s) begin
      chk("R3 oe", {a_oe_o, b_oe_o, par_oe_o}, 3'b000);
      chk("R3 out", {a_out_o, b_out_o, par_out_o}, '0);
      chk("R9 err dis", err_no, 1'b1);
    end else if (d) begin
      chk("R1 b_out", b_out_o, a);
      chk("R1 oe", {a_oe_o, b_oe_o}, 2'b01);
      chk("R10 a_out", a_out_o, '0);
      chk(o ? "R5 par" : "R4 par", par_out_o, exp_par(a, o));
      chk("R6 par_oe tx", par_oe_o, 1'b1);
      chk("R9 err tx", err_no, 1'b1);
    end else begin
      chk("R2 a_out", a_out_o, b);
      chk("R2 oe", {a_oe_o, b_oe_o}, 2'b10);
      chk("R10 b_out", b_out_o, '0);
      chk("R6 par_oe rx", par_oe_o, 1'b0);
      chk(o ? "R8 err" : "R7 err", err_no, exp_err_n(d, s, o, b, p));
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0657));
    dir_i = 1'b0; dis_i = 1'b1; odd_i = 1'b0; a_in_i = '0; b_in_i = '0; par_in_i = 1'b0;
    repeat (2) @(posedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // reset-time state: disabled, nothing driven
    chk("R3 reset oe", {a_oe_o, b_oe_o, par_oe_o}, 3'b000);
    chk("R9 reset err", err_no, 1'b1);

    // directed corners
    apply(1'b1, 1'b0, 1'b0, 8'h00, 8'hff, 1'b1);
    apply(1'b1, 1'b0, 1'b0, 8'h01, 8'h00, 1'b0);
    apply(1'b1, 1'b0, 1'b1, 8'hff, 8'h00, 1'b0);
    apply(1'b0, 1'b0, 1'b0, 8'h01, 8'h00, 1'b1);
    apply(1'b0, 1'b0, 1'b0, 8'h00, 8'h01, 1'b1);
    apply(1'b0, 1'b0, 1'b1, 8'h55, 8'hff, 1'b0);
    apply(1'b0, 1'b1, 1'b1, 8'haa, 8'h00, 1'b1);

    // exhaustive sweep: other side and parity pin carry unrelated values
    for (int v = 0; v < 256; v++)
      for (int d = 0; d < 2; d++)
        for (int o = 0; o < 2; o++)
          for (int s = 0; s < 2; s++)
            for (int p = 0; p < 2; p++)
              apply(d[0], s[0], o[0], v[7:0], ~v[7:0] ^ 8'h3c, p[0]);

    // random mix
    for (int i = 0; i < 2000; i++)
      apply(1'($urandom), 1'($urandom % 4 == 0), 1'($urandom),
            8'($urandom), 8'($urandom), 1'($urandom));

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule